// File: doc/BRIEF.md
# Rotate-and-Mask Field Extractor

This block pulls a bit field out of one 32-bit operand, or deposits one into another, in a single pass. The M operand goes through a full left rotator, so every bit survives at some position. A mask then marks a contiguous run of bit positions. The registered result takes the rotated M bit wherever the mask is set and the A operand bit wherever it is clear. Extraction uses an A operand of zero. Deposit uses the destination word as the A operand.

The rotate amount comes from a 5-bit field and can be changed in two ways. A force-zero flag drops it to zero, which is used for selective deposit. A byte-stream flag swaps its two upper bits for the two low bits of an external macro program counter, so that a byte or halfword is selected with no extra cycle. The mask's right edge is either zero or the effective rotate amount. Its left edge is the right edge plus a width field. The unregistered rotator output is also brought out, for use as a dispatch address.

Top module: `rot_mask_unit`

## Requirements
- R1: `rot_out` equals `m_in` rotated left by the effective amount in the same cycle: bit i of the output is bit (i − amount) mod 32 of the input, so no bit is lost.
- R2: With `zero_rot` = 1 the effective amount is 0, whatever `byte_mode`, `lc_bits` and `rot_amt` hold.
- R3: With `zero_rot` = 0 and `byte_mode` = 1 the effective amount is {`lc_bits`[1], `lc_bits`[0], `rot_amt`[2:0]}, with `lc_bits`[1] in amount bit 4. With both flags at 0 it is `rot_amt`.
- R4: The mask's right edge is 0 when `right_sel` = 0 and the effective amount when `right_sel` = 1.
- R5: The left edge is (right edge + `width`) mod 32. The mask includes both edges, so `width` = 0 selects exactly one bit and `width` = 31 with right edge 0 selects all 32 bits.
- R6: When the left edge wraps below the right edge, the mask covers only the bits from the right edge up through bit 31.
- R7: For every bit i, the next result bit is `rot_out`[i] where mask bit i is 1 and `a_in`[i] where it is 0.
- R8: `result_q` shows the selection one clock after the inputs are presented. While `rst` is high at a rising edge, `result_q` is cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| m_in | input | 32 | Operand that is rotated |
| a_in | input | 32 | Operand that fills bits outside the mask |
| rot_amt | input | 5 | Requested rotate amount |
| width | input | 5 | Field width minus one |
| zero_rot | input | 1 | Forces the effective rotate amount to 0 |
| right_sel | input | 1 | 0: right edge at bit 0; 1: right edge at the effective amount |
| byte_mode | input | 1 | Replaces amount bits 4:3 with `lc_bits` |
| lc_bits | input | 2 | Low bits of the macro program counter |
| rot_out | output | 32 | Rotated M operand, unregistered |
| result_q | output | 32 | Registered masked result |

## Verification
The bench targets the wrapped left edge. A design that compared the edges without treating wrap-around as a special case would return an empty mask there, or one that fills in the low bits. It also checks single-bit fields at width 0, where an exclusive left edge would select nothing. It tests that the force-zero flag overrides byte-stream mode, where a wrong priority would rotate by the program counter bits. It also checks that `lc_bits` lands in amount bits 4:3 in that order, since swapping them would pick the wrong byte. Pseudo-random operand and control mixes against a bench model catch off-by-one rotation and a swapped select polarity.

// File: rtl/fx_pkg.sv
package fx_pkg;

    // Number of rotate-amount bits taken over by the byte-stream counter
    localparam int FX_LC_W = 2;

    // Source of the mask's right edge
    typedef enum logic {
        EDGE_ZERO = 1'b0,
        EDGE_ROT  = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/fx_amtsel.sv
module fx_amtsel #(
    parameter int AW  = 5,
    parameter int LCW = 2
) (
    input  logic [AW-1:0]  rot_amt,
    input  logic           zero_rot,
    input  logic           byte_mode,
    input  logic [LCW-1:0] lc_bits,
    output logic [AW-1:0]  eff_amt
);

    localparam int LOW_W = AW - LCW;

    always_comb begin
        if (zero_rot) begin
            eff_amt = '0;
        end else if (byte_mode) begin
            eff_amt = {lc_bits, rot_amt[LOW_W-1:0]};
        end else begin
            eff_amt = rot_amt;
        end
    end

endmodule

// File: rtl/fx_rotl.sv
module fx_rotl #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amt,
    output logic [DW-1:0] dout
);

    // stg[s] holds the word after the first s binary stages
    logic [AW:0][DW-1:0] stg;

    assign stg[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        for (genvar i = 0; i < DW; i++) begin : g_bit
            localparam int SRC = (i + DW - (SH % DW)) % DW;
            assign stg[s+1][i] = amt[s] ? stg[s][SRC] : stg[s][i];
        end
    end

    assign dout = stg[AW];

endmodule

// File: rtl/fx_mask.sv
module fx_mask #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic [AW-1:0] right_edge,
    input  logic [AW-1:0] width,
    output logic [DW-1:0] mask
);

    logic [AW-1:0] left_edge;
    logic          wrapped;
    logic [DW-1:0] from_right;   // ones at and above the right edge
    logic [DW-1:0] to_left;      // ones at and below the left edge

    assign left_edge = right_edge + width;
    assign wrapped   = left_edge < right_edge;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam logic [AW-1:0] IDX = AW'(i);
        assign from_right[i] = IDX >= right_edge;
        assign to_left[i]    = (IDX <= left_edge) | wrapped;
        assign mask[i]       = from_right[i] & to_left[i];
    end

endmodule

// File: rtl/rot_mask_unit.sv
module rot_mask_unit
    import fx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DW-1:0]              m_in,
    input  logic [DW-1:0]              a_in,
    input  logic [$clog2(DW)-1:0]      rot_amt,
    input  logic [$clog2(DW)-1:0]      width,
    input  logic                       zero_rot,
    input  logic                       right_sel,
    input  logic                       byte_mode,
    input  logic [FX_LC_W-1:0]         lc_bits,
    output logic [DW-1:0]              rot_out,
    output logic [DW-1:0]              result_q
);

    localparam int AW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] result;
    } fx_state_t;

    fx_state_t     st_d, st_q;
    logic [AW-1:0] eff_amt;
    logic [AW-1:0] right_edge;
    logic [DW-1:0] rot_w;
    logic [DW-1:0] mask_w;

    fx_amtsel #(.AW(AW), .LCW(FX_LC_W)) u_amt (
        .rot_amt   (rot_amt),
        .zero_rot  (zero_rot),
        .byte_mode (byte_mode),
        .lc_bits   (lc_bits),
        .eff_amt   (eff_amt)
    );

    fx_rotl #(.DW(DW), .AW(AW)) u_rot (
        .din  (m_in),
        .amt  (eff_amt),
        .dout (rot_w)
    );

    assign right_edge = (edge_sel_e'(right_sel) == EDGE_ROT) ? eff_amt : '0;

    fx_mask #(.DW(DW), .AW(AW)) u_mask (
        .right_edge (right_edge),
        .width      (width),
        .mask       (mask_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.result = (rot_w & mask_w) | (a_in & ~mask_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rot_out  = rot_w;
    assign result_q = st_q.result;

endmodule

// File: rtl/fx_chk.sv
module fx_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] m_in,
    input logic [31:0] a_in,
    input logic [4:0]  rot_amt,
    input logic [4:0]  width,
    input logic        zero_rot,
    input logic        right_sel,
    input logic        byte_mode,
    input logic [1:0]  lc_bits,
    input logic [31:0] rot_out,
    input logic [31:0] result_q
);

    // R1
    rot_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rot_out) == $countones(m_in));

    // R2
    zero_rot_passes_chk: assert property (@(posedge clk) disable iff (rst)
        zero_rot |-> rot_out == m_in);

    // R3
    byte_zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_rot && byte_mode && lc_bits == 2'b00 && rot_amt[2:0] == 3'd0)
        |-> rot_out == m_in);

    // R5
    full_field_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_rot && !right_sel && width == 5'd31) |=> result_q == $past(m_in));

    // R6
    wrap_top_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_rot && byte_mode && right_sel && lc_bits == 2'b11 &&
         rot_amt[2:0] == 3'd7 && width == 5'd1)
        |=> result_q[30:0] == $past(a_in[30:0]));

    // R7
    same_ops_chk: assert property (@(posedge clk) disable iff (rst)
        (m_in == a_in && zero_rot) |=> result_q == $past(a_in));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> result_q == 32'd0);

endmodule

bind rot_mask_unit fx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .m_in      (m_in),
    .a_in      (a_in),
    .rot_amt   (rot_amt),
    .width     (width),
    .zero_rot  (zero_rot),
    .right_sel (right_sel),
    .byte_mode (byte_mode),
    .lc_bits   (lc_bits),
    .rot_out   (rot_out),
    .result_q  (result_q)
);

// File: tb/rot_mask_unit_test.sv
module rot_mask_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] m_in, a_in;
    logic [4:0]  rot_amt, width;
    logic        zero_rot, right_sel, byte_mode;
    logic [1:0]  lc_bits;
    logic [31:0] rot_out, result_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;  // 125 MHz

    rot_mask_unit uut (
        .clk(clk), .rst(rst), .m_in(m_in), .a_in(a_in), .rot_amt(rot_amt),
        .width(width), .zero_rot(zero_rot), .right_sel(right_sel),
        .byte_mode(byte_mode), .lc_bits(lc_bits), .rot_out(rot_out),
        .result_q(result_q)
    );

    function automatic logic [4:0] model_amt(logic [4:0] amt, logic z, logic bm, logic [1:0] lc);
        if (z) return 5'd0;
        if (bm) return {lc, amt[2:0]};
        return amt;
    endfunction

    function automatic logic [31:0] model_rot(logic [31:0] m, logic [4:0] k);
        logic [63:0] dbl;
        dbl = {m, m} << k;
        return dbl[63:32];
    endfunction

    function automatic logic [31:0] model_mask(logic [4:0] r, logic [4:0] w);
        logic [31:0] mk;
        int          lft;
        lft = (int'(r) + int'(w)) % 32;
        for (int i = 0; i < 32; i++)
            mk[i] = (i >= int'(r)) && ((lft < int'(r)) || (i <= lft));
        return mk;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one vector, checks rot_out, queues the expected result
    task automatic apply(string tag, logic [31:0] m, logic [31:0] a, logic [4:0] amt,
                         logic [4:0] w, logic z, logic rs, logic bm, logic [1:0] lc);
        logic [4:0]  k;
        logic [31:0] rt, mk;
        @(negedge clk);
        m_in = m; a_in = a; rot_amt = amt; width = w;
        zero_rot = z; right_sel = rs; byte_mode = bm; lc_bits = lc;
        k  = model_amt(amt, z, bm, lc);
        rt = model_rot(m, k);
        mk = model_mask(rs ? k : 5'd0, w);
        #1;
        check({tag, " rot_out"}, rot_out, rt);
        exp_q.push_back((rt & mk) | (a & ~mk));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the registered result one edge after each vector
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " result"}, result_q, e);
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        m_in = '0; a_in = '0; rot_amt = '0; width = '0;
        zero_rot = 0; right_sel = 0; byte_mode = 0; lc_bits = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", result_q, 32'd0);
        rst = 1'b0;

        // R1 plain rotate by 5, full mask
        apply("R1", 32'h8000_0001, 32'h0, 5'd5, 5'd31, 0, 0, 0, 2'b00);
        apply("R1", 32'hF000_000F, 32'h0, 5'd31, 5'd31, 0, 0, 0, 2'b00);
        // R2 force-zero beats byte mode
        apply("R2", 32'hDEAD_BEEF, 32'h0, 5'd7, 5'd31, 1, 1, 1, 2'b11);
        // R3 lc_bits=10 into bits 4:3, low bits 001 -> amount 17
        apply("R3", 32'h0000_0001, 32'h0, 5'b11001, 5'd31, 0, 0, 1, 2'b10);
        apply("R3", 32'h0000_00A5, 32'h0, 5'b00000, 5'd31, 0, 0, 1, 2'b01);
        // R4 right edge at amount 8, width 7 -> byte 15:8
        apply("R4", 32'h0000_0055, 32'hFFFF_FFFF, 5'd8, 5'd7, 0, 1, 0, 2'b00);
        apply("R4", 32'h0000_0055, 32'hFFFF_FFFF, 5'd8, 5'd7, 0, 0, 0, 2'b00);
        // R5 single bit field
        apply("R5", 32'hFFFF_FFFF, 32'h0, 5'd12, 5'd0, 0, 1, 0, 2'b00);
        apply("R5", 32'h0000_0000, 32'hFFFF_FFFF, 5'd0, 5'd0, 0, 1, 0, 2'b00);
        // R6 wrap: right 28, width 7 -> bits 31:28 only
        apply("R6", 32'hFFFF_FFFF, 32'h0, 5'd28, 5'd7, 0, 1, 0, 2'b00);
        apply("R6", 32'h0000_0000, 32'h1234_5678, 5'd31, 5'd31, 0, 1, 0, 2'b00);
        // R7 deposit pattern
        apply("R7", 32'h0000_00C3, 32'hAAAA_AAAA, 5'd4, 5'd7, 0, 1, 0, 2'b00);

        // R7 pseudo-random mixes
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r1, r2, r3;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; r1 = seed;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; r2 = seed;
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; r3 = seed;
            apply("R7 rand", r1, r2, r3[4:0], r3[9:5], r3[10] & r3[11],
                  r3[12], r3[13], r3[15:14]);
        end

        @(negedge clk);
        @(negedge clk);
        // R8 reset mid-run clears a nonzero result
        apply("R8", 32'hFFFF_FFFF, 32'h0, 5'd0, 5'd31, 0, 0, 0, 2'b00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset", result_q, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule